// File: doc/BRIEF.md
# Multi-Cycle 32-bit Processor Core

This block is a small non-pipelined processor. A control sequencer takes each instruction through fetch, decode, execute, an optional memory phase and writeback. The sequencer drives a word-indexed program counter, a 32-entry register file and an ALU. The core uses two memory ports. The instruction port is a synchronous read port: the address is presented in one cycle and the word arrives in the next. The data port is also synchronous: it has a write strobe and returns read data one cycle after the address.

The instruction set covers register arithmetic and logic (add, sub, and, or, nor, signed set-less-than). It also covers add-immediate, word load and store, and the two conditional branches on equality and inequality. A terminate opcode stops the core. After each instruction retires, a 2-bit status code reports the outcome: a register-form instruction, an immediate-form instruction, a signed overflow, or termination. Once the terminate opcode is decoded, the core raises a halted flag and stays in that state until reset.

Top module: `mc_cpu_core`

## Requirements
- R1: Register-form instructions take the opcode from bits [31:26], the first source register from [25:21], the second source from [20:16] and the destination from [15:11]. Opcodes: add 0x00, sub 0x01, and 0x02, or 0x03, nor 0x04, slt 0x05.
- R2: Immediate-form instructions take the opcode from [31:26], the base or source register from [25:21], the destination or store-data register from [20:16], and a 16-bit immediate from [15:0]. The immediate is sign-extended. Opcodes: addi 0x08, lw 0x09, sw 0x0A, beq 0x0B, bne 0x0C.
- R3: The ALU operations give two's-complement sum and difference, bitwise and, or and nor. Slt writes 1 when the first source is less than the second as a signed value, and 0 otherwise.
- R4: Counted from the clock edge that ends the fetch phase, an instruction that does not touch memory retires 4 cycles after its fetch begins, and a load or store retires 5 cycles after its fetch begins. Only load and store pass through the memory phase.
- R5: A store raises the data write strobe for exactly one cycle. The data address is the low bits of base + immediate, as a word index, and the write data is the store-data register. A load writes the returned data word into its destination register.
- R6: The PC changes only at retirement. A taken beq/bne moves it to PC+1+immediate; every other instruction moves it to PC+1.
- R7: When add, sub or addi produces a signed overflow, the destination register keeps its old value and the status is 2.
- R8: The status is 0 after a register-form instruction and 1 after an immediate-form instruction (load, store and branches included). Any unassigned opcode does nothing and reports 0.
- R9: Register 0 always reads as zero; writes to it are discarded.
- R10: Opcode 0x3F raises the halted output and sets the status to 3 two cycles after its fetch begins. From then on the PC stays frozen and no further data write occurs.
- R11: Reset (synchronous, active high) sets the PC to 0, the status to 0 and the halted flag to 0, and restarts the core at fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction word address (the PC) |
| imem_rdata | input | 32 | Instruction word, valid one cycle after address |
| dmem_addr | output | DADDR_W | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | XLEN | Load data, valid one cycle after address |
| halted | output | 1 | Core has stopped on the terminate opcode |
| status | output | 2 | Outcome code of the last retired instruction |

## Verification
The bench builds the core with its defaults: XLEN=32, PC_W=8 and DADDR_W=8. An 8-bit PC holds the 34-word test program together with its forward branches. An 8-bit data address reaches the low words, which hold preloaded extreme operands (largest positive, most negative) used to provoke overflow. It also reaches the words at 16 and above, where the program stores its results for inspection. With a 32-bit datapath, carries out of bit 31 and sign flips of add, sub and addi can be checked against exact wrap values.

// File: rtl/mc_cpu_pkg.sv
package mc_cpu_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4,
        ST_HALT   = 3'd5
    } fsm_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT
    } alu_op_e;

    localparam logic [5:0] OPC_ADD  = 6'h00;
    localparam logic [5:0] OPC_SUB  = 6'h01;
    localparam logic [5:0] OPC_AND  = 6'h02;
    localparam logic [5:0] OPC_OR   = 6'h03;
    localparam logic [5:0] OPC_NOR  = 6'h04;
    localparam logic [5:0] OPC_SLT  = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LW   = 6'h09;
    localparam logic [5:0] OPC_SW   = 6'h0A;
    localparam logic [5:0] OPC_BEQ  = 6'h0B;
    localparam logic [5:0] OPC_BNE  = 6'h0C;
    localparam logic [5:0] OPC_EOF  = 6'h3F;

    typedef struct packed {
        alu_op_e alu_op;
        logic    imm_b;     // second operand is the immediate
        logic    is_itype;
        logic    wr_en;     // writes a register at retirement
        logic    dst_rt;    // destination from [20:16]
        logic    chk_ovf;   // overflow suppresses the write
        logic    is_load;
        logic    is_store;
        logic    is_beq;
        logic    is_bne;
    } ctrl_t;

    function automatic ctrl_t decode_opc(input logic [5:0] opc);
        ctrl_t c;
        c = '0;
        c.alu_op = ALU_ADD;
        case (opc)
            OPC_ADD:  begin c.wr_en = 1'b1; c.chk_ovf = 1'b1; end
            OPC_SUB:  begin c.wr_en = 1'b1; c.chk_ovf = 1'b1; c.alu_op = ALU_SUB; end
            OPC_AND:  begin c.wr_en = 1'b1; c.alu_op = ALU_AND; end
            OPC_OR:   begin c.wr_en = 1'b1; c.alu_op = ALU_OR;  end
            OPC_NOR:  begin c.wr_en = 1'b1; c.alu_op = ALU_NOR; end
            OPC_SLT:  begin c.wr_en = 1'b1; c.alu_op = ALU_SLT; end
            OPC_ADDI: begin
                c.wr_en = 1'b1; c.imm_b = 1'b1; c.is_itype = 1'b1;
                c.dst_rt = 1'b1; c.chk_ovf = 1'b1;
            end
            OPC_LW:   begin
                c.wr_en = 1'b1; c.imm_b = 1'b1; c.is_itype = 1'b1;
                c.dst_rt = 1'b1; c.is_load = 1'b1;
            end
            OPC_SW:   begin c.imm_b = 1'b1; c.is_itype = 1'b1; c.is_store = 1'b1; end
            OPC_BEQ:  begin c.is_itype = 1'b1; c.is_beq = 1'b1; end
            OPC_BNE:  begin c.is_itype = 1'b1; c.is_bne = 1'b1; end
            default:  c = c;   // unassigned opcodes retire as register-form no-ops
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mc_cpu_alu.sv
module mc_cpu_alu
    import mc_cpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         en,
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         ovf
);

    logic [W-1:0] sum, diff;
    assign sum  = a + b;
    assign diff = a - b;

    always_comb begin
        y   = '0;
        ovf = 1'b0;
        if (en) begin
            case (op)
                ALU_ADD: begin
                    y   = sum;
                    ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
                end
                ALU_SUB: begin
                    y   = diff;
                    ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
                end
                ALU_AND: y = a & b;
                ALU_OR:  y = a | b;
                ALU_NOR: y = ~(a | b);
                ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
                default: y = '0;
            endcase
        end
    end

    // only the arithmetic operations may flag overflow, and only while enabled
    always_comb begin
        AST_OVF_ONLY_ARITH: assert (!ovf || (en && (op == ALU_ADD || op == ALU_SUB))); // R7
    end

endmodule

// File: rtl/mc_cpu_regfile.sv
module mc_cpu_regfile #(
    parameter int W  = 32,
    parameter int AW = 5,
    localparam int N = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

endmodule

// File: rtl/mc_cpu_core.sv
module mc_cpu_core
    import mc_cpu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PC_W    = 8,
    parameter int DADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [31:0]        imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_we,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               halted,
    output logic [1:0]         status
);

    localparam int REG_AW = 5;
    localparam int IMM_W  = 16;

    typedef struct packed {
        fsm_e            state;
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] npc;
        logic [31:0]     ir;
        logic [XLEN-1:0] res;
        logic            ovf;
        logic [1:0]      status;
    } core_t;

    core_t r_q, r_d;

    // instruction fields
    logic [5:0]        opc;
    logic [REG_AW-1:0] rs, rt, rd;
    logic [XLEN-1:0]   simm;
    ctrl_t             ctrl;

    assign opc  = r_q.ir[31:26];
    assign rs   = r_q.ir[25:21];
    assign rt   = r_q.ir[20:16];
    assign rd   = r_q.ir[15:11];
    assign simm = {{(XLEN-IMM_W){r_q.ir[IMM_W-1]}}, r_q.ir[IMM_W-1:0]};
    assign ctrl = decode_opc(opc);

    // register file
    logic [XLEN-1:0]   rs_val, rt_val, wb_data;
    logic [REG_AW-1:0] wb_addr;
    logic              wb_en;

    assign wb_en   = (r_q.state == ST_WB) && ctrl.wr_en && !r_q.ovf;
    assign wb_addr = ctrl.dst_rt ? rt : rd;
    assign wb_data = ctrl.is_load ? dmem_rdata : r_q.res;

    mc_cpu_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk     (clk),
        .we      (wb_en),
        .waddr   (wb_addr),
        .wdata   (wb_data),
        .raddr_a (rs),
        .rdata_a (rs_val),
        .raddr_b (rt),
        .rdata_b (rt_val)
    );

    // ALU, active only in execute
    logic [XLEN-1:0] alu_y;
    logic            alu_ovf;

    mc_cpu_alu #(.W(XLEN)) u_alu (
        .en  (r_q.state == ST_EXEC),
        .op  (ctrl.alu_op),
        .a   (rs_val),
        .b   (ctrl.imm_b ? simm : rt_val),
        .y   (alu_y),
        .ovf (alu_ovf)
    );

    logic br_taken;
    assign br_taken = (ctrl.is_beq && (rs_val == rt_val)) ||
                      (ctrl.is_bne && (rs_val != rt_val));

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_FETCH:  r_d.state = ST_DECODE;
            ST_DECODE: begin
                r_d.ir = imem_rdata;
                if (imem_rdata[31:26] == OPC_EOF) begin
                    r_d.state  = ST_HALT;
                    r_d.status = 2'd3;
                end else begin
                    r_d.state = ST_EXEC;
                end
            end
            ST_EXEC: begin
                r_d.res = alu_y;
                r_d.ovf = alu_ovf && ctrl.chk_ovf;
                r_d.npc = br_taken ? (r_q.pc + PC_W'(1) + simm[PC_W-1:0])
                                   : (r_q.pc + PC_W'(1));
                r_d.state = (ctrl.is_load || ctrl.is_store) ? ST_MEM : ST_WB;
            end
            ST_MEM:    r_d.state = ST_WB;
            ST_WB: begin
                r_d.pc     = r_q.npc;
                r_d.status = r_q.ovf ? 2'd2 : (ctrl.is_itype ? 2'd1 : 2'd0);
                r_d.state  = ST_FETCH;
            end
            ST_HALT:   r_d.state = ST_HALT;
            default:   r_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;   // ST_FETCH encodes as zero
        end else begin
            r_q <= r_d;
        end
    end

    assign imem_addr  = r_q.pc;
    assign dmem_addr  = r_q.res[DADDR_W-1:0];
    assign dmem_wdata = rt_val;
    assign dmem_we    = (r_q.state == ST_MEM) && ctrl.is_store;
    assign halted     = (r_q.state == ST_HALT);
    assign status     = r_q.status;

    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> (r_q.state == ST_WB) && !dmem_we); // R5

    AST_NO_MEM_SKIP: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_EXEC && !ctrl.is_load && !ctrl.is_store) |=> (r_q.state == ST_WB)); // R4

    AST_PC_ONLY_AT_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (r_q.state != ST_WB) |=> $stable(imem_addr)); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && !dmem_we); // R10

    AST_HALT_STATUS: assert property (@(posedge clk) disable iff (rst)
        halted |-> (status == 2'd3)); // R10

endmodule

// File: tb/mc_cpu_core_test.sv
`timescale 1ns/1ps
module mc_cpu_core_test;

    localparam logic [5:0] K_ADD = 6'h00, K_SUB = 6'h01, K_AND = 6'h02, K_OR = 6'h03;
    localparam logic [5:0] K_NOR = 6'h04, K_SLT = 6'h05, K_ADDI = 6'h08, K_LW = 6'h09;
    localparam logic [5:0] K_SW = 6'h0A, K_BEQ = 6'h0B, K_BNE = 6'h0C, K_EOF = 6'h3F;

    // execution trace: {pc after retirement, status, cycles from fetch to retirement}
    localparam int NTR = 31;
    localparam logic [12:0] TRACE [NTR] = '{
        {8'd1, 2'd1, 3'd4}, {8'd2, 2'd1, 3'd4}, {8'd3, 2'd0, 3'd4}, {8'd4, 2'd0, 3'd4},
        {8'd5, 2'd0, 3'd4}, {8'd6, 2'd0, 3'd4}, {8'd7, 2'd0, 3'd4}, {8'd8, 2'd0, 3'd4},
        {8'd9, 2'd0, 3'd4}, {8'd10, 2'd1, 3'd4}, {8'd11, 2'd1, 3'd5}, {8'd12, 2'd1, 3'd5},
        {8'd13, 2'd2, 3'd4}, {8'd14, 2'd2, 3'd4}, {8'd15, 2'd2, 3'd4}, {8'd16, 2'd1, 3'd4},
        {8'd18, 2'd1, 3'd4}, {8'd19, 2'd1, 3'd4}, {8'd21, 2'd1, 3'd4}, {8'd22, 2'd1, 3'd4},
        {8'd23, 2'd0, 3'd4}, {8'd24, 2'd1, 3'd5}, {8'd25, 2'd1, 3'd5}, {8'd26, 2'd1, 3'd5},
        {8'd27, 2'd1, 3'd5}, {8'd28, 2'd1, 3'd5}, {8'd29, 2'd1, 3'd5}, {8'd30, 2'd1, 3'd5},
        {8'd31, 2'd1, 3'd5}, {8'd32, 2'd1, 3'd5}, {8'd33, 2'd1, 3'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [31:0] imem_rdata;
    logic [7:0]  dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;
    logic        halted;
    logic [1:0]  status;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];
    int errors = 0;
    int checks = 0;
    int we_count = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_cpu_core uut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .halted(halted), .status(status)
    );

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr];
        if (dmem_we) begin
            dmem[dmem_addr] <= dmem_wdata;
            we_count <= we_count + 1;
        end
    end

    function automatic logic [31:0] rt_ins(logic [5:0] o, int s1, int s2, int d);
        return {o, 5'(s1), 5'(s2), 5'(d), 11'd0};
    endfunction

    function automatic logic [31:0] it_ins(logic [5:0] o, int s, int t, logic [15:0] imm);
        return {o, 5'(s), 5'(t), imm};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            imem[i] = it_ins(K_EOF, 0, 0, 16'h0);
            dmem[i] = 32'h0;
        end
        dmem[0] = 32'h7FFF_FFFF;
        dmem[1] = 32'h8000_0000;
        imem[0]  = it_ins(K_ADDI, 0, 1, 16'd5);
        imem[1]  = it_ins(K_ADDI, 0, 2, 16'hFFFD);
        imem[2]  = rt_ins(K_ADD, 1, 2, 3);
        imem[3]  = rt_ins(K_SUB, 1, 2, 4);
        imem[4]  = rt_ins(K_AND, 1, 2, 5);
        imem[5]  = rt_ins(K_OR, 1, 2, 6);
        imem[6]  = rt_ins(K_NOR, 1, 2, 7);
        imem[7]  = rt_ins(K_SLT, 2, 1, 8);
        imem[8]  = rt_ins(K_SLT, 1, 2, 9);
        imem[9]  = it_ins(K_ADDI, 0, 11, 16'd7);
        imem[10] = it_ins(K_LW, 0, 10, 16'd0);
        imem[11] = it_ins(K_LW, 0, 12, 16'd1);
        imem[12] = rt_ins(K_ADD, 10, 1, 11);
        imem[13] = rt_ins(K_SUB, 12, 1, 11);
        imem[14] = it_ins(K_ADDI, 10, 11, 16'd1);
        imem[15] = it_ins(K_ADDI, 0, 0, 16'd9);
        imem[16] = it_ins(K_BEQ, 1, 1, 16'd1);
        imem[17] = it_ins(K_ADDI, 0, 11, 16'd99);
        imem[18] = it_ins(K_BNE, 1, 1, 16'd5);
        imem[19] = it_ins(K_BNE, 1, 2, 16'd1);
        imem[20] = it_ins(K_ADDI, 0, 11, 16'd55);
        imem[21] = it_ins(K_BEQ, 1, 2, 16'd3);
        imem[22] = {6'h20, 26'h3FF_FFFF};
        imem[23] = it_ins(K_SW, 0, 3, 16'd16);
        imem[24] = it_ins(K_SW, 0, 4, 16'd17);
        imem[25] = it_ins(K_SW, 0, 5, 16'd18);
        imem[26] = it_ins(K_SW, 0, 6, 16'd19);
        imem[27] = it_ins(K_SW, 0, 7, 16'd20);
        imem[28] = it_ins(K_SW, 0, 8, 16'd21);
        imem[29] = it_ins(K_SW, 0, 9, 16'd22);
        imem[30] = it_ins(K_SW, 0, 11, 16'd23);
        imem[31] = it_ins(K_SW, 0, 0, 16'd24);
        imem[32] = it_ins(K_SW, 0, 10, 16'd25);
        imem[33] = it_ins(K_EOF, 0, 0, 16'h0);

        repeat (3) @(posedge clk);
        #1;
        check("R11 reset pc", 32'(imem_addr), 32'd0);
        check("R11 reset status", 32'(status), 32'd0);
        check("R11 reset halted", 32'(halted), 32'd0);
        rst = 1'b0;

        // table walk: one entry per retired instruction
        for (int i = 0; i < NTR; i++) begin
            logic [7:0] prev;
            int n;
            prev = imem_addr;
            n = 0;
            do begin
                @(posedge clk);
                #1;
                n++;
            end while (imem_addr == prev && n < 12);
            check("R6 pc after retirement", 32'(imem_addr), 32'(TRACE[i][12:5]));
            check("R8 status code", 32'(status), 32'(TRACE[i][4:3]));
            check("R4 cycles per instruction", 32'(n), 32'(TRACE[i][2:0]));
        end

        // terminate opcode at word 33
        begin
            int n;
            n = 0;
            do begin
                @(posedge clk);
                #1;
                n++;
            end while (!halted && n < 12);
            check("R10 halt latency", 32'(n), 32'd2);
            check("R10 halted status", 32'(status), 32'd3);
        end
        repeat (10) @(posedge clk);
        #1;
        check("R10 halted stays", 32'(halted), 32'd1);
        check("R10 pc frozen", 32'(imem_addr), 32'd33);
        check("R5 store count", 32'(we_count), 32'd10);

        check("R1 add result", dmem[16], 32'd2);
        check("R3 sub result", dmem[17], 32'd8);
        check("R3 and result", dmem[18], 32'd5);
        check("R2 sign-extended or result", dmem[19], 32'hFFFF_FFFD);
        check("R3 nor result", dmem[20], 32'd2);
        check("R3 slt true", dmem[21], 32'd1);
        check("R3 slt false", dmem[22], 32'd0);
        check("R7 overflow keeps destination", dmem[23], 32'd7);
        check("R9 register zero", dmem[24], 32'd0);
        check("R5 load data", dmem[25], 32'h7FFF_FFFF);

        // reset out of the halted state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R11 reset clears pc", 32'(imem_addr), 32'd0);
        check("R11 reset clears status", 32'(status), 32'd0);
        check("R11 reset clears halted", 32'(halted), 32'd0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check("R11 restart first retirement", 32'(imem_addr), 32'd1);
        check("R8 restart status", 32'(status), 32'd1);

        done = 1'b1;
        finish_run();
    end

endmodule